// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that stores bytes like a serial EEPROM with two-byte addressing. The master selects it with a 7-bit device address made of the fixed prefix `1010` and three strap inputs. A write carries a 16-bit memory address and then data bytes. The data bytes collect in a 128-byte page buffer and reach the storage array only when the STOP condition ends the write. A timed commit window follows, and during it the target ignores its own address.

Reads come in three forms. A random read sets the address with a write and then reads after a repeated START. A current-address read starts at the location held by the internal address pointer. Any read continues as a sequential read for as long as the master acknowledges.

Writes and reads move through memory differently. Writes wrap inside their 128-byte page. Reads run straight across page boundaries and wrap only at the end of memory.

The bus lines are open-drain. SCL and SDA arrive as plain inputs. The target drives SDA through an output enable, where 1 pulls the line low. The parameter `MEM_AW` sets the size of the array. Its default of 11 gives 16 pages so that default elaboration stays small, and setting it to 16 gives 512 pages and 64 KiB. Straps that a board leaves unconnected must be tied to 0 at the integration level.

Top module: `ee_i2c_target`

## Requirements
- R1: The target acknowledges a device address byte only when its upper seven bits equal `1010` followed by `strap_i[2]`, `strap_i[1]`, `strap_i[0]`, with bit 0 as read (1) or write (0). With all straps high the write byte is 0xAE and the read byte is 0xAF. Any other address gets no acknowledge, and the target stays off the bus until the next START.
- R2: After reset SDA is released, and every memory location reads 0xFF.
- R3: In a write, the first two bytes after the device address are the memory address, high byte first. Each later data byte goes to the next address. The target acknowledges every address and data byte.
- R4: A write that passes offset 127 of a page continues at offset 0 of the same page, and the page bits of the address stay unchanged.
- R5: A write that buffered at least one byte is committed when its STOP arrives. For `COMMIT_CYC` clock cycles after that, the target does not acknowledge its device address, and it acknowledges again afterwards. A write that carried only an address starts no commit window.
- R6: While `wp_i` is 1, data bytes are still acknowledged but none is stored, and no commit window starts.
- R7: A random read works as follows: a write of the device address and the two address bytes, a repeated START, then the read device address. It returns data starting at that address.
- R8: A read without a preceding address write starts at the current address. After a write the current address is the last written location plus one, wrapped within its page. After a read it is the last read location plus one, wrapped over the whole memory.
- R9: A sequential read increments through the whole address space, crosses page boundaries, and continues from the last location to address 0.
- R10: When the master answers a read byte with NACK, the target releases SDA and sends no further byte.
- R11: Within one write, a later byte that lands on the same wrapped page offset replaces the earlier byte.
- R12: The target changes SDA only while SCL is low. It never produces a START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | SDA pull-down enable (1 = drive low) |
| strap_i | input | 3 | Device address straps, bit 2 is the most significant |
| wp_i | input | 1 | Write protect, active high |

## Verification
The risky overlap is between the commit of one write and the device-address decode of the next transaction. The bench therefore sends a new address byte right after a write's STOP and expects a NACK, then probes again once the window has closed and expects an ACK.

The second overlap is inside the page buffer, where a byte that wraps past offset 127 lands on a slot that already holds data. A 130-byte write provokes this, and read-back judges it. A behavioural model predicts every acknowledge and every returned byte, and per-clock monitors watch for SDA contention and for SDA changes while SCL is high.

// File: rtl/ee_pkg.sv
package ee_pkg;
  localparam int PAGE_AW = 7;
  localparam logic [3:0] DEV_PREFIX = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK
  } bus_st_e;

  typedef enum logic [1:0] {
    K_DEV, K_AHI, K_ALO, K_DATA
  } rx_kind_e;
endpackage

// File: rtl/ee_line_sync.sv
module ee_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_o   = scl_q[STAGES-1];
  assign sda_o   = sda_q[STAGES-1];
  assign rise_o  = scl_o & ~scl_d;
  assign fall_o  = ~scl_o & scl_d;
  // SDA edges while SCL stays high
  assign start_o = scl_o & scl_d & ~sda_o & sda_d;
  assign stop_o  = scl_o & scl_d & sda_o & ~sda_d;
endmodule

// File: rtl/ee_store.sv
module ee_store #(
  parameter int AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  input  logic          we_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (we_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf
  import ee_pkg::*;
#(
  parameter int AW         = 11,
  parameter int COMMIT_CYC = 1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic          commit_i,
  output logic          busy_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_waddr_o,
  output logic [7:0]    mem_wdata_o
);
  localparam int PAGE_SZ = 1 << PAGE_AW;
  localparam int CW      = $clog2(COMMIT_CYC + 1);

  logic [7:0]            buf_q [PAGE_SZ];
  logic [PAGE_SZ-1:0]    vld_q;
  logic [AW-PAGE_AW-1:0] page_q;
  logic                  busy_q;
  logic [CW-1:0]         cnt_q;
  logic [PAGE_AW-1:0]    slot;
  logic                  drain;

  // one slot drained per cycle at the start of the window
  assign slot        = cnt_q[PAGE_AW-1:0];
  assign drain       = busy_q && (cnt_q < CW'(PAGE_SZ));
  assign mem_we_o    = drain && vld_q[slot];
  assign mem_waddr_o = {page_q, slot};
  assign mem_wdata_o = buf_q[slot];
  assign busy_o      = busy_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) buf_q[wr_addr_i[PAGE_AW-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      page_q <= '0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (clear_i) vld_q <= '0;
      if (mem_we_o) vld_q[slot] <= 1'b0;
      if (wr_en_i) begin
        vld_q[wr_addr_i[PAGE_AW-1:0]] <= 1'b1;
        page_q <= wr_addr_i[AW-1:PAGE_AW];
      end
      if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(COMMIT_CYC - 1)) busy_q <= 1'b0;
      end else if (commit_i && |vld_q) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end
  end
endmodule

// File: rtl/ee_i2c_target.sv
module ee_i2c_target
  import ee_pkg::*;
#(
  parameter int MEM_AW      = 11,
  parameter int COMMIT_CYC  = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);
  localparam logic [PAGE_AW-1:0] OFF_ONE = 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic busy, mem_we;
  logic [MEM_AW-1:0] mem_waddr;
  logic [7:0] mem_wdata, rd_data;

  bus_st_e  st_q;
  rx_kind_e kind_q;
  logic [3:0]        bit_q;
  logic [7:0]        sh_q;
  logic [MEM_AW-9:0] hi_q;
  logic [MEM_AW-1:0] ptr_q;
  logic rd_q, mack_q, oe_q;

  logic byte_done, dev_hit, buf_clr, buf_we;

  ee_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .rise_o(scl_rise), .fall_o(scl_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  ee_store #(.AW(MEM_AW)) i_store (
    .clk_i, .rst_ni,
    .rd_addr_i(ptr_q), .rd_data_o(rd_data),
    .we_i(mem_we), .wr_addr_i(mem_waddr), .wr_data_i(mem_wdata)
  );

  ee_page_buf #(.AW(MEM_AW), .COMMIT_CYC(COMMIT_CYC)) i_pbuf (
    .clk_i, .rst_ni,
    .clear_i(buf_clr), .wr_en_i(buf_we), .wr_addr_i(ptr_q), .wr_data_i(sh_q),
    .commit_i(stop_evt), .busy_o(busy),
    .mem_we_o(mem_we), .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata)
  );

  always_comb begin
    byte_done = (st_q == ST_RX) && scl_fall && (bit_q == 4'd8) && !start_evt && !stop_evt;
    dev_hit   = (sh_q[7:1] == {DEV_PREFIX, strap_i}) && !busy;
    buf_clr   = byte_done && (kind_q == K_ALO);
    buf_we    = byte_done && (kind_q == K_DATA) && !wp_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      kind_q <= K_DEV;
      bit_q  <= '0;
      sh_q   <= '0;
      hi_q   <= '0;
      ptr_q  <= '0;
      rd_q   <= 1'b0;
      mack_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (start_evt) begin
      st_q   <= ST_RX;
      kind_q <= K_DEV;
      bit_q  <= '0;
      oe_q   <= 1'b0;
    end else if (stop_evt) begin
      st_q <= ST_IDLE;
      oe_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise) begin
            sh_q  <= {sh_q[6:0], sda_s};
            bit_q <= bit_q + 1'b1;
          end else if (byte_done) begin
            st_q <= ST_ACK;
            oe_q <= 1'b1;
            unique case (kind_q)
              K_DEV: begin
                if (!dev_hit) begin
                  st_q <= ST_IDLE;
                  oe_q <= 1'b0;
                end
                rd_q   <= sh_q[0];
                kind_q <= K_AHI;
              end
              K_AHI: begin
                hi_q   <= sh_q[MEM_AW-9:0];
                kind_q <= K_ALO;
              end
              K_ALO: begin
                ptr_q  <= {hi_q, sh_q};
                kind_q <= K_DATA;
              end
              K_DATA: ptr_q <= {ptr_q[MEM_AW-1:PAGE_AW], ptr_q[PAGE_AW-1:0] + OFF_ONE};
              default: ;
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bit_q <= '0;
            if (rd_q) begin
              sh_q  <= rd_data;
              ptr_q <= ptr_q + MEM_AW'(1);
              oe_q  <= ~rd_data[7];
              st_q  <= ST_TX;
            end else begin
              oe_q <= 1'b0;
              st_q <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_q == 4'd7) begin
              oe_q <= 1'b0;
              st_q <= ST_MACK;
            end else begin
              sh_q  <= {sh_q[6:0], 1'b0};
              oe_q  <= ~sh_q[6];
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              bit_q <= '0;
              sh_q  <= rd_data;
              ptr_q <= ptr_q + MEM_AW'(1);
              oe_q  <= ~rd_data[7];
              st_q  <= ST_TX;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/ee_chk.sv
module ee_chk #(
  parameter int COMMIT_CYC = 1000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s_i,
  input logic sda_oe_i,
  input logic busy_i,
  input logic stop_i
);
  int unsigned busy_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_len_q <= 0;
    else if (busy_i) busy_len_q <= busy_len_q + 1;
    else busy_len_q <= 0;
  end

  // R12
  oe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_s_i && $past(scl_s_i) |-> $stable(sda_oe_i));

  // R12
  oe_pull_low_scl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_i) |-> !scl_s_i);

  // R5
  busy_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !sda_oe_i);

  // R5
  commit_after_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(stop_i));

  // R5
  commit_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> busy_len_q == unsigned'(COMMIT_CYC));
endmodule

bind ee_i2c_target ee_chk #(.COMMIT_CYC(COMMIT_CYC)) i_ee_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .sda_oe_i(sda_oe_o),
  .busy_i(busy), .stop_i(stop_evt)
);

// File: tb/test_ee_i2c_target.sv
module test_ee_i2c_target;
  localparam int MEM_AW = 11;
  localparam int MEM_SZ = 1 << MEM_AW;
  localparam int COMMIT_CYC = 1000;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, msda = 1'b1;
  logic [2:0] strap = 3'b111;
  logic wp = 1'b0;
  logic sda_oe_o, sda_line;

  assign sda_line = msda & ~sda_oe_o;

  always #10 clk = ~clk;

  ee_i2c_target #(.MEM_AW(MEM_AW), .COMMIT_CYC(COMMIT_CYC)) i_ee_i2c_target (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe_o), .strap_i(strap), .wp_i(wp)
  );

  int n_run = 0, n_fail = 0;
  int clash_cnt = 0, hold_viol = 0, scl_hi_run = 0;
  logic own = 1'b0, oe_prev = 1'b0;
  bit done = 0;

  logic [7:0] ref_mem [MEM_SZ];
  int ref_ptr = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  // per-clock monitors: contention and SDA stability while SCL high (R12)
  always @(negedge clk) begin
    if (own && sda_oe_o) clash_cnt++;
    if (scl) scl_hi_run++; else scl_hi_run = 0;
    if (rst_n && scl_hi_run > 4 && sda_oe_o !== oe_prev) hold_viol++;
    oe_prev = sda_oe_o;
  end

  task automatic bit_out(input logic b);
    msda = b; wq(1);
    scl = 1'b1; own = 1'b1; wq(2);
    own = 1'b0; scl = 1'b0; wq(1);
  endtask

  task automatic bit_in(output logic b);
    msda = 1'b1; wq(1);
    scl = 1'b1; wq(1);
    b = sda_line; wq(1);
    scl = 1'b0; wq(1);
  endtask

  task automatic start_c;
    msda = 1'b1; wq(1);
    scl = 1'b1; wq(2);
    msda = 1'b0; wq(2);
    scl = 1'b0; wq(1);
  endtask

  task automatic stop_c;
    msda = 1'b0; wq(1);
    scl = 1'b1; wq(2);
    msda = 1'b1; wq(2);
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic ack);
    logic lb;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(lb);
    ack = !lb;
  endtask

  task automatic rx_byte(output logic [7:0] b, input logic mack);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      bit_in(x);
      b[i] = x;
    end
    bit_out(!mack);
  endtask

  function automatic logic [7:0] dev_w();
    return {4'b1010, strap, 1'b0};
  endfunction

  task automatic probe(input logic [7:0] dev, input logic exp_ack, input string req);
    logic a;
    start_c;
    tx_byte(dev, a);
    chk(req, a, exp_ack);
    stop_c;
  endtask

  task automatic wr(input int addr, input int n, input int seed, input string req);
    logic a;
    logic [7:0] pend [int];
    int p;
    start_c;
    tx_byte(dev_w(), a); chk({req, " dev ack"}, a, 1);
    tx_byte(8'((addr >> 8) & 255), a); chk("R3 addr hi ack", a, 1);
    tx_byte(8'(addr & 255), a); chk("R3 addr lo ack", a, 1);
    p = addr & (MEM_SZ - 1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'((seed + i + (i >> 7) * 5) & 8'h7F);
      tx_byte(d, a);
      chk({req, " data ack"}, a, 1);
      if (!wp) pend[p] = d;
      p = (p & ~127) | ((p + 1) & 127);
    end
    stop_c;
    ref_ptr = p;
    if (pend.num() > 0) begin
      foreach (pend[k]) ref_mem[k] = pend[k];
      probe(dev_w(), 1'b0, "R5 busy nack");
      repeat (COMMIT_CYC + 100) @(negedge clk);
      probe(dev_w(), 1'b1, "R5 ack after window");
    end
  endtask

  task automatic rd_body(input int n, input string req);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      rx_byte(d, i < n - 1);
      chk(req, d, ref_mem[ref_ptr]);
      ref_ptr = (ref_ptr + 1) & (MEM_SZ - 1);
    end
    chk("R10 released after nack", sda_oe_o, 0);
    stop_c;
  endtask

  task automatic rd_rand(input int addr, input int n, input string req);
    logic a;
    start_c;
    tx_byte(dev_w(), a); chk("R7 dev ack", a, 1);
    tx_byte(8'((addr >> 8) & 255), a); chk("R7 addr hi ack", a, 1);
    tx_byte(8'(addr & 255), a); chk("R7 addr lo ack", a, 1);
    start_c;
    tx_byte(dev_w() | 8'h01, a); chk("R7 read dev ack", a, 1);
    ref_ptr = addr & (MEM_SZ - 1);
    rd_body(n, req);
  endtask

  task automatic rd_cur(input int n, input string req);
    logic a;
    start_c;
    tx_byte(dev_w() | 8'h01, a); chk("R8 read dev ack", a, 1);
    rd_body(n, req);
  endtask

  initial begin
    for (int i = 0; i < MEM_SZ; i++) ref_mem[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wq(4);
    chk("reset sda released", sda_oe_o, 0);

    rd_rand(16'h0000, 4, "R2 erased");
    rd_rand(16'h05F0, 2, "R2 erased");

    probe(8'hA0, 1'b0, "R1 foreign addr");
    probe(8'hAE, 1'b1, "R1 straps 111");
    strap = 3'b010;
    probe(8'hA4, 1'b1, "R1 straps 010");
    probe(8'hAE, 1'b0, "R1 old straps");
    strap = 3'b111;

    wr(16'h0123, 4, 8'h10, "R3");
    rd_rand(16'h0122, 6, "R3 readback");
    rd_cur(2, "R8 after read");

    wr(16'h017C, 8, 8'h20, "R4");
    rd_rand(16'h0178, 12, "R4 page end");
    rd_rand(16'h0100, 5, "R4 wrapped head");

    wr(16'h0300, 130, 8'h30, "R11");
    rd_cur(2, "R8 after write");
    rd_rand(16'h0300, 3, "R11 overwrite");
    rd_rand(16'h037E, 4, "R9 page cross");

    wr(16'h07FE, 2, 8'h40, "R9 setup");
    wr(16'h0000, 1, 8'h50, "R9 setup");
    rd_rand(16'h07FD, 5, "R9 end wrap");

    wp = 1'b1;
    wr(16'h0200, 3, 8'h60, "R6");
    probe(dev_w(), 1'b1, "R6 no commit window");
    wp = 1'b0;
    rd_rand(16'h0200, 3, "R6 unchanged");

    begin
      logic a;
      start_c;
      tx_byte(dev_w(), a); chk("R5 dev ack", a, 1);
      tx_byte(8'h01, a); chk("R5 addr hi ack", a, 1);
      tx_byte(8'h24, a); chk("R5 addr lo ack", a, 1);
      stop_c;
      ref_ptr = 16'h0124;
      probe(dev_w(), 1'b1, "R5 address-only no window");
      rd_cur(3, "R8 after address set");
    end

    chk("R12 no contention", clash_cnt, 0);
    chk("R12 sda stable scl high", hold_viol, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule